// File: doc/BRIEF.md
# Table-Driven Memory Access Reference Monitor

This block is the single gate between several requesting cores and one shared memory port. Every core presents a valid/ready request with a read/write flag and an address. A round-robin arbiter takes one request at a time. The accepted address is decoded into a range index. The requesting core, the operation and the range together form a symbol. That symbol and the current policy state address a transition table. Each table entry holds a next state and an accept bit. An accepted access is forwarded to the memory side. A rejected access is blocked and reported.

The table sits in a writable on-chip RAM, so a policy can be replaced without changing any logic. Because the decision walks a state machine, the block can enforce fixed per-range permissions. It can also enforce stateful policies, where one access narrows or widens what later accesses may do. An isolation policy is the simplest case: each core may touch only its own range, in any order and any number of times. The requester identity is the arbiter port index, so a core cannot claim to be another core.

Top module: `mem_ref_monitor`

## Requirements
- R1: After reset the policy state is 0 (the start state), `mem_valid` and `viol_valid` are low, and no `req_ready` bit is high while no core requests.
- R2: Until `tbl_done` has been seen high since reset, every request is denied with a violation pulse. A new reset clears this loaded condition.
- R3: The table is indexed as {state, core index, write flag, range index}, from the most significant bit down. In each entry, bit 0 is the accept bit and the upper SW bits are the next state.
- R4: Range k covers the addresses from `RANGE_LO[k]` to `RANGE_HI[k]`, bounds included. With the default parameters the ranges are 0x1000–0x1FFF, 0x2000–0x2FFF and 0x3000–0x3FFF, and the lowest matching index wins.
- R5: An address outside every range takes the reserved range code NR (3 by default). Such an access is denied even when the table entry says accept.
- R6: A granted access puts one single-cycle pulse on `mem_valid`, carrying the core index, write flag and address. The pulse appears at the second rising edge after the accept edge.
- R7: A denied access never raises `mem_valid`. It raises `viol_valid` for one cycle with the offending core index in `viol_core`, at the same point a grant would appear, and leaves the policy state unchanged.
- R8: On a grant, the policy state takes the next-state field of the table entry that was read. The state changes at no other time.
- R9: At most one `req_ready` bit is high. It is high only for a core that is requesting, and never while a check is in flight. The winner is the first requesting core after the last accepted one, in rotating order.
- R10: A table write (`tbl_we` with address and data) changes the entry used by later checks, including after the loaded condition is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NC | Per-core request valid |
| req_ready | output | NC | Per-core accept, one-hot or zero |
| req_write | input | NC | Per-core operation, 1 = write |
| req_addr | input | NC*AW | Per-core address, core i at bits [i*AW +: AW] |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | SW+CW+1+RW | Table write address |
| tbl_wdata | input | SW+1 | Table entry {next state, accept} |
| tbl_done | input | 1 | Marks the table as loaded (sticky until reset) |
| mem_valid | output | 1 | Granted transaction pulse to memory |
| mem_write | output | 1 | Operation of the granted transaction |
| mem_addr | output | AW | Address of the granted transaction |
| mem_core | output | CW | Core index of the granted transaction |
| viol_valid | output | 1 | Violation pulse |
| viol_core | output | CW | Core index of the denied access |
| cur_state | output | SW | Current policy state |

## Verification
The assertions assume that each requester follows the handshake: it holds valid, the write flag and the address steady until its ready bit is seen. They also assume that table writes do not hit the entry being read by a check in flight. The bench changes inputs only at falling edges. It lowers a core's valid at the falling edge right after that core is accepted. It writes the table only while no request is pending. `tbl_done` is raised only after every entry has been written.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // position of the accept flag inside a table entry
    localparam int ACCEPT_BIT = 0;
endpackage

// File: rtl/rm_rr_arbiter.sv
module rm_rr_arbiter #(
    parameter int NC = 2,
    localparam int CW = $clog2(NC)
)(
    input  logic [NC-1:0] req,
    input  logic          enable,
    input  logic [CW-1:0] last,
    output logic [NC-1:0] grant_oh,
    output logic [CW-1:0] grant_idx,
    output logic          grant_any
);
    logic found;

    always_comb begin
        int idx;
        found     = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= NC; k++) begin
            idx = (int'(last) + k) % NC;
            if (!found && req[idx]) begin
                found     = 1'b1;
                grant_idx = CW'(idx);
            end
        end
        grant_any = found && enable;
        grant_oh  = grant_any ? (NC'(1) << grant_idx) : '0;
    end
endmodule

// File: rtl/rm_range_dec.sv
module rm_range_dec #(
    parameter int AW = 16,
    parameter int NR = 3,
    parameter logic [NR*AW-1:0] LO = '0,
    parameter logic [NR*AW-1:0] HI = '0,
    localparam int RW = $clog2(NR + 1)
)(
    input  logic [AW-1:0] addr,
    output logic [RW-1:0] range_id
);
    always_comb begin
        range_id = RW'(NR);
        // descending walk: the lowest matching index is written last and wins
        for (int k = NR - 1; k >= 0; k--) begin
            if (addr >= LO[k*AW +: AW] && addr <= HI[k*AW +: AW]) begin
                range_id = RW'(k);
            end
        end
    end
endmodule

// File: rtl/rm_policy_ram.sv
module rm_policy_ram #(
    parameter int AW = 6,
    parameter int DW = 3,
    localparam int DEPTH = 1 << AW
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/mem_ref_monitor.sv
module mem_ref_monitor
    import refmon_pkg::*;
#(
    parameter int NC = 2,
    parameter int AW = 16,
    parameter int NR = 3,
    parameter int SW = 2,
    parameter logic [NR*AW-1:0] RANGE_LO = {16'h3000, 16'h2000, 16'h1000},
    parameter logic [NR*AW-1:0] RANGE_HI = {16'h3FFF, 16'h2FFF, 16'h1FFF},
    localparam int CW   = $clog2(NC),
    localparam int RW   = $clog2(NR + 1),
    localparam int SYMW = CW + 1 + RW,
    localparam int TAW  = SW + SYMW,
    localparam int EW   = SW + 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NC-1:0]    req_valid,
    output logic [NC-1:0]    req_ready,
    input  logic [NC-1:0]    req_write,
    input  logic [NC*AW-1:0] req_addr,
    input  logic             tbl_we,
    input  logic [TAW-1:0]   tbl_addr,
    input  logic [EW-1:0]    tbl_wdata,
    input  logic             tbl_done,
    output logic             mem_valid,
    output logic             mem_write,
    output logic [AW-1:0]    mem_addr,
    output logic [CW-1:0]    mem_core,
    output logic             viol_valid,
    output logic [CW-1:0]    viol_core,
    output logic [SW-1:0]    cur_state
);
    localparam logic [RW-1:0] NO_RANGE = RW'(NR);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] core;
        logic          wr;
        logic [AW-1:0] addr;
        logic [RW-1:0] rng;
        logic [SW-1:0] state;
        logic          loaded;
        logic [CW-1:0] last;
        logic          mv;
        logic          mw;
        logic [AW-1:0] ma;
        logic [CW-1:0] mc;
        logic          vv;
        logic [CW-1:0] vc;
    } regs_t;

    regs_t r_d, r_q;

    logic [CW-1:0]  pick;
    logic           take;
    logic [AW-1:0]  sel_addr;
    logic [RW-1:0]  sel_rng;
    logic [TAW-1:0] rd_addr;
    logic [EW-1:0]  rd_entry;
    logic           allow;

    rm_rr_arbiter #(.NC(NC)) u_arb (
        .req       (req_valid),
        .enable    (!r_q.busy),
        .last      (r_q.last),
        .grant_oh  (req_ready),
        .grant_idx (pick),
        .grant_any (take)
    );

    assign sel_addr = req_addr[int'(pick) * AW +: AW];

    rm_range_dec #(.AW(AW), .NR(NR), .LO(RANGE_LO), .HI(RANGE_HI)) u_rng (
        .addr     (sel_addr),
        .range_id (sel_rng)
    );

    // symbol = {core, op, range}; table address = {state, symbol}
    assign rd_addr = {r_q.state, pick, req_write[pick], sel_rng};

    rm_policy_ram #(.AW(TAW), .DW(EW)) u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .re    (take),
        .raddr (rd_addr),
        .rdata (rd_entry)
    );

    assign allow = r_q.loaded && (r_q.rng != NO_RANGE) && rd_entry[ACCEPT_BIT];

    always_comb begin
        r_d      = r_q;
        r_d.mv   = 1'b0;
        r_d.vv   = 1'b0;
        r_d.busy = 1'b0;
        if (tbl_done) begin
            r_d.loaded = 1'b1;
        end
        if (take) begin
            r_d.busy = 1'b1;
            r_d.core = pick;
            r_d.wr   = req_write[pick];
            r_d.addr = sel_addr;
            r_d.rng  = sel_rng;
            r_d.last = pick;
        end
        if (r_q.busy) begin
            if (allow) begin
                r_d.state = rd_entry[EW-1:1];
                r_d.mv    = 1'b1;
                r_d.mw    = r_q.wr;
                r_d.ma    = r_q.addr;
                r_d.mc    = r_q.core;
            end else begin
                r_d.vv = 1'b1;
                r_d.vc = r_q.core;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.last <= CW'(NC - 1);
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_valid  = r_q.mv;
    assign mem_write  = r_q.mw;
    assign mem_addr   = r_q.ma;
    assign mem_core   = r_q.mc;
    assign viol_valid = r_q.vv;
    assign viol_core  = r_q.vc;
    assign cur_state  = r_q.state;
endmodule

module refmon_chk #(
    parameter int NC = 2,
    parameter int SW = 2
)(
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] req_valid,
    input logic [NC-1:0] req_ready,
    input logic          mem_valid,
    input logic          viol_valid,
    input logic [SW-1:0] cur_state,
    input logic          loaded
);
    // R9
    ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    // R9
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    // R7
    grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_valid && viol_valid));

    // R7
    deny_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> $stable(cur_state));

    // R8
    state_moves_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != $past(cur_state)) |-> mem_valid);

    // R2
    grant_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> loaded);

    // R6
    grant_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> $past(|(req_valid & req_ready), 2));

    // R6
    grant_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |=> !mem_valid);
endmodule

bind mem_ref_monitor refmon_chk #(.NC(NC), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .mem_valid  (mem_valid),
    .viol_valid (viol_valid),
    .cur_state  (cur_state),
    .loaded     (r_q.loaded)
);

// File: tb/mem_ref_monitor_bench.sv
`timescale 1ns/1ps
module mem_ref_monitor_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  req_valid;
    logic [1:0]  req_ready;
    logic [1:0]  req_write;
    logic [31:0] req_addr;
    logic        tbl_we;
    logic [5:0]  tbl_addr;
    logic [2:0]  tbl_wdata;
    logic        tbl_done;
    logic        mem_valid;
    logic        mem_write;
    logic [15:0] mem_addr;
    logic        mem_core;
    logic        viol_valid;
    logic        viol_core;
    logic [1:0]  cur_state;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mem_ref_monitor u_mem_ref_monitor (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .tbl_done(tbl_done),
        .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_core(mem_core),
        .viol_valid(viol_valid), .viol_core(viol_core),
        .cur_state(cur_state)
    );

    // {core, write, addr[15:0], grant, state[1:0], tag[1:0]}
    // tag: 0 grant path R6, 1 deny path R7, 2 range edge R4, 3 outside ranges R5
    localparam logic [22:0] VEC [12] = '{
        {1'b0, 1'b0, 16'h1004, 1'b1, 2'd0, 2'd0},
        {1'b0, 1'b1, 16'h1FFF, 1'b1, 2'd0, 2'd2},
        {1'b1, 1'b1, 16'h2000, 1'b1, 2'd0, 2'd2},
        {1'b0, 1'b0, 16'h2000, 1'b0, 2'd0, 2'd1},
        {1'b1, 1'b0, 16'h1000, 1'b0, 2'd0, 2'd1},
        {1'b0, 1'b0, 16'h0FFF, 1'b0, 2'd0, 2'd3},
        {1'b1, 1'b1, 16'h3000, 1'b0, 2'd0, 2'd1},
        {1'b0, 1'b1, 16'h3000, 1'b1, 2'd1, 2'd0},
        {1'b1, 1'b1, 16'h2004, 1'b0, 2'd1, 2'd1},
        {1'b0, 1'b1, 16'h1000, 1'b0, 2'd1, 2'd1},
        {1'b0, 1'b0, 16'h1000, 1'b1, 2'd1, 2'd0},
        {1'b0, 1'b0, 16'h4000, 1'b0, 2'd1, 2'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Policy under test, R3 layout: addr = {state, core, write, range}, entry = {next, accept}.
    // State 0: isolation (core0 <-> range0, core1 <-> range1); a core0 write into range2
    // moves to state 1, where only core0 reads of range0 pass. Denied entries point at
    // state 3 so a wrong state update shows. Range code 3 entries claim accept (R5).
    function automatic logic [2:0] policy(input logic [5:0] a);
        logic [1:0] st;
        logic       c;
        logic       w;
        logic [1:0] r;
        st = a[5:4]; c = a[3]; w = a[2]; r = a[1:0];
        if (r == 2'd3) return {2'd3, 1'b1};
        if (st == 2'd0) begin
            if (!c && r == 2'd0) return {2'd0, 1'b1};
            if (c && r == 2'd1)  return {2'd0, 1'b1};
            if (!c && w && r == 2'd2) return {2'd1, 1'b1};
        end else if (st == 2'd1) begin
            if (!c && !w && r == 2'd0) return {2'd1, 1'b1};
        end
        return {2'd3, 1'b0};
    endfunction

    task automatic load_table();
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            tbl_we    = 1'b1;
            tbl_addr  = 6'(a);
            tbl_wdata = policy(6'(a));
        end
        @(negedge clk);
        tbl_we   = 1'b0;
        tbl_done = 1'b1;
        @(negedge clk);
        tbl_done = 1'b0;
    endtask

    // drive one request; on return (falling edge) the decision outputs are valid
    task automatic do_req(input logic c, input logic w, input logic [15:0] a);
        @(negedge clk);
        req_valid[c] = 1'b1;
        req_write[c] = w;
        req_addr[c*16 +: 16] = a;
        @(posedge clk);
        @(negedge clk);
        req_valid[c] = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_deny(input string tag, input logic c, input logic [1:0] st);
        chk({tag, " mem_valid"}, 32'(mem_valid), 32'd0);
        chk({tag, " viol_valid"}, 32'(viol_valid), 32'd1);
        chk({tag, " viol_core"}, 32'(viol_core), 32'(c));
        chk("R7 state kept", 32'(cur_state), 32'(st));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = '0; req_write = '0; req_addr = '0;
        tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; tbl_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cur_state", 32'(cur_state), 32'd0);
        chk("R1 mem_valid", 32'(mem_valid), 32'd0);
        chk("R1 viol_valid", 32'(viol_valid), 32'd0);
        chk("R1 req_ready idle", 32'(req_ready), 32'd0);

        // R2 denied before the table is marked loaded
        do_req(1'b0, 1'b0, 16'h1000);
        expect_deny("R2 unloaded", 1'b0, 2'd0);

        load_table();

        // R9 round robin: core0 was accepted last, so core1 wins first
        @(negedge clk);
        req_valid = 2'b11;
        req_write = 2'b10;
        req_addr  = {16'h2000, 16'h1000};
        #1;
        chk("R9 first winner", 32'(req_ready), 32'b10);
        @(posedge clk);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1;
        chk("R9 no ready in flight", 32'(req_ready), 32'b00);
        @(posedge clk);
        @(negedge clk);
        chk("R9 core1 granted", 32'(mem_valid), 32'd1);
        chk("R9 core1 id", 32'(mem_core), 32'd1);
        chk("R9 next winner", 32'(req_ready), 32'b01);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 core0 id", 32'(mem_core), 32'd0);
        chk("R6 core0 granted", 32'(mem_valid), 32'd1);

        // vector table
        for (int i = 0; i < 12; i++) begin
            logic        c;
            logic        w;
            logic [15:0] a;
            logic        g;
            logic [1:0]  st;
            string       t;
            {c, w, a, g, st} = VEC[i][22:2];
            case (VEC[i][1:0])
                2'd0: t = $sformatf("R6 vec%0d", i);
                2'd1: t = $sformatf("R7 vec%0d", i);
                2'd2: t = $sformatf("R4 vec%0d", i);
                default: t = $sformatf("R5 vec%0d", i);
            endcase
            do_req(c, w, a);
            if (g) begin
                chk({t, " mem_valid"}, 32'(mem_valid), 32'd1);
                chk({t, " mem_core"}, 32'(mem_core), 32'(c));
                chk({t, " mem_write"}, 32'(mem_write), 32'(w));
                chk({t, " mem_addr"}, 32'(mem_addr), 32'(a));
                chk({t, " viol_valid"}, 32'(viol_valid), 32'd0);
                chk("R8 state", 32'(cur_state), 32'(st));
            end else begin
                expect_deny(t, c, st);
            end
            @(negedge clk);
            chk({t, " pulse ends"}, 32'(mem_valid | viol_valid), 32'd0);
        end

        // R10 / R3: rewrite entry {state1, core1, write, range1} to accept, stay in state 1
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = {2'd1, 1'b1, 1'b1, 2'd1}; tbl_wdata = {2'd1, 1'b1};
        @(negedge clk);
        tbl_we = 1'b0;
        do_req(1'b1, 1'b1, 16'h2008);
        chk("R10 rewritten entry grants", 32'(mem_valid), 32'd1);
        chk("R3 next state field", 32'(cur_state), 32'd1);

        // R1 / R2: reset again returns to start state and clears the loaded condition
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 state after reset", 32'(cur_state), 32'd0);
        do_req(1'b0, 1'b0, 16'h1000);
        expect_deny("R2 reloaded needed", 1'b0, 2'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule